// File: doc/BRIEF.md
# T1 Framing Bit Error Monitor

This block watches the framing bits of a T1 receive stream that an upstream framer has already aligned. Each cycle it may take one received bit. A strobe marks the framing bit at the start of every 193-bit frame, and the framer supplies the frame number within the multiframe, an SF/ESF format select and an in-sync flag. The block compares every framing bit that carries alignment information with its expected value. It raises a single-error event on any mismatch and a severe-error event when mismatches cluster inside a fixed window. In ESF mode it also computes a CRC-6 over each extended superframe and checks it against the check bits that arrive in the following superframe.

Every event lands in a sticky 8-bit indication register that software clears by writing ones. The register also holds a multiframe-start flag and a change-of-frame-alignment flag supplied by the framer. An interrupt output combines the register with per-bit enables. Frame indices are 0-based: SF uses indices 0..11 and ESF uses 0..23. All events are set in the register on the clock edge that samples the framing-bit strobe.

Top module: `t1_fbit_monitor`

## Requirements
- R1: In SF mode, a framing bit at an even index 2k is a terminal bit, expected 1,0,1,0,1,0 for k=0..5. A framing bit at an odd index 2k+1 is a signalling bit, expected 0,0,1,1,1,0. Any mismatch sets bit 2 of the register.
- R2: In SF mode, bit 4 is set when a second terminal-bit mismatch falls in the same fixed window. The windows are indices 0..5 and 6..11. Signalling-bit mismatches do not count, and errors in two different windows do not combine.
- R3: In ESF mode, the framing bit at index 4k+3 is an alignment bit, expected 0,0,1,0,1,1 for k=0..5, and any mismatch sets bit 2. Framing bits at other indices never set bit 2.
- R4: In ESF mode, bit 4 is set when two or more alignment-bit mismatches fall within one multiframe, counting from index 0.
- R5: The CRC-6 (generator x^6+x+1, seeded to zero, fed MSB-first one bit per received bit) runs over every bit of an ESF multiframe, with each framing bit taken as 1. The check bits arrive at indices 4k+1 of the next multiframe: k=0 carries remainder bit 5 and k=5 carries remainder bit 0. Any mismatch sets bit 3 once per multiframe.
- R6: No CRC check is made in the first ESF multiframe after sync is regained or after ESF mode is entered.
- R7: Bit 5 is set on the framing bit at index 0 while in sync. While out of sync, bit 5 is neither set nor cleared.
- R8: While out of sync, no framing, severe or CRC event is raised, and the window counters and CRC state are cleared.
- R9: A write with a 1 in a bit position clears that bit only. A hardware set in the same cycle as a clear leaves the bit at 1.
- R10: After reset all bits read 0. Bit 1 is set by the change-of-alignment input. Bits 7, 6 and 0 always read 0.
- R11: The interrupt output is high exactly when some register bit and its enable are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_bit | input | 1 | Received serial bit |
| bit_valid | input | 1 | rx_bit is valid this cycle |
| fbit_strobe | input | 1 | Current bit is the framing bit of a frame |
| frame_idx | input | 5 | Frame index within the multiframe, valid with the strobe |
| esf_mode | input | 1 | 1 = ESF, 0 = SF |
| in_sync | input | 1 | Framer reports alignment |
| cofa_in | input | 1 | Change-of-frame-alignment pulse from the framer |
| wr_en | input | 1 | Write strobe for the indication register |
| wr_data | input | 8 | Write-one-to-clear mask |
| irq_en | input | 8 | Per-bit interrupt enables |
| ind_flags | output | 8 | Indication register |
| irq | output | 1 | Interrupt request |

## Verification
The main checker is driven with whole multiframes carrying chosen sets of framing-bit flips. Single flips on terminal and signalling positions separate the two SF bit kinds. A pair of flips inside one window and a pair straddling the window edge separate a fixed window from a sliding one. In ESF, flips on alignment, data-link and check positions show that only alignment bits feed the error flags and only check bits feed the CRC flag. Two flipped check bits confirm that a multiframe raises one CRC event. Resync and mode-entry sequences show that the first CRC check is skipped, and out-of-sync traffic with errors shows that nothing is flagged.

// File: rtl/t1fm_pkg.sv
// Shared constants and the CRC-6 step function for the T1 framing bit monitor.
// Assumes frame indices are 0-based within the multiframe.
package t1fm_pkg;
    localparam int IDX_W = 5;
    localparam int CRC_W = 6;
    localparam int REG_W = 8;
    localparam logic [CRC_W-1:0] CRC_POLY = 6'b000011;

    // Indication register bit positions
    localparam int B_COFA = 1;
    localparam int B_FBIT = 2;
    localparam int B_CRC  = 3;
    localparam int B_SEV  = 4;
    localparam int B_MFB  = 5;
    localparam logic [REG_W-1:0] LIVE_MASK = 8'b0011_1110;

    // Expected framing values, entry k in bit k
    localparam logic [5:0] SF_TERM_PAT = 6'b010101;
    localparam logic [5:0] SF_SIG_PAT  = 6'b011100;
    localparam logic [5:0] ESF_ALN_PAT = 6'b110100;

    // One serial CRC-6 step, MSB first
    function automatic logic [CRC_W-1:0] crc_step(input logic [CRC_W-1:0] c, input logic d);
        logic fb;
        fb = c[CRC_W-1] ^ d;
        return {c[CRC_W-2:0], 1'b0} ^ (fb ? CRC_POLY : '0);
    endfunction
endpackage

// File: rtl/t1fm_fbit_check.sv
// Framing-bit pattern checker with fixed-window severe-error counting.
// Assumes frame_idx is valid whenever fbit_strobe is high. Events are
// combinational and qualified by in_sync.
module t1fm_fbit_check
    import t1fm_pkg::*;
#(
    parameter int SEV_LIMIT = 2,
    parameter int SF_WIN    = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_valid,
    input  logic             fbit_strobe,
    input  logic             rx_bit,
    input  logic [IDX_W-1:0] frame_idx,
    input  logic             esf_mode,
    input  logic             in_sync,
    output logic             fe_evt,
    output logic             sev_evt,
    output logic             mfb_evt
);
    localparam int CNT_W = $clog2(SEV_LIMIT + 1);
    localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(SEV_LIMIT);
    localparam logic [CNT_W-1:0] CNT_PRE = CNT_W'(SEV_LIMIT - 1);

    logic             f_tick;
    logic             is_term, is_sig, is_aln;
    logic [2:0]       slot_sf, slot_esf;
    logic             exp_bit, mismatch, counted, win_start;
    logic [CNT_W-1:0] cnt_q, cnt_base;

    // Classify the framing bit and look up its expected value
    always_comb begin
        f_tick   = bit_valid && fbit_strobe && in_sync;
        slot_sf  = frame_idx[3:1];
        slot_esf = frame_idx[4:2];
        is_term  = !esf_mode && !frame_idx[0];
        is_sig   = !esf_mode &&  frame_idx[0];
        is_aln   =  esf_mode && (frame_idx[1:0] == 2'b11);
        if (is_term)     exp_bit = SF_TERM_PAT[slot_sf];
        else if (is_sig) exp_bit = SF_SIG_PAT[slot_sf];
        else             exp_bit = ESF_ALN_PAT[slot_esf];
        mismatch = (rx_bit != exp_bit);
    end

    // Window restart, event generation
    always_comb begin
        win_start = (frame_idx == '0) || (!esf_mode && frame_idx == IDX_W'(SF_WIN));
        cnt_base  = win_start ? '0 : cnt_q;
        counted   = f_tick && (is_term || is_aln) && mismatch;
        fe_evt    = f_tick && (is_term || is_sig || is_aln) && mismatch;
        sev_evt   = counted && (cnt_base >= CNT_PRE);
        mfb_evt   = f_tick && (frame_idx == '0);
    end

    // Saturating error counter for the current fixed window
    always_ff @(posedge clk) begin
        if (!rst_n || !in_sync)
            cnt_q <= '0;
        else if (f_tick) begin
            if (counted && cnt_base != CNT_TOP) cnt_q <= cnt_base + 1'b1;
            else                                cnt_q <= cnt_base;
        end
    end

    AST_WIN_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        !in_sync |=> (cnt_q == '0)); // R8
    AST_SIG_NOT_SEVERE: assert property (@(posedge clk) disable iff (!rst_n)
        (!esf_mode && fbit_strobe && frame_idx[0]) |-> !sev_evt); // R2
endmodule

// File: rtl/t1fm_crc6.sv
// ESF CRC-6 accumulator and checker. Holds the remainder of the previous
// multiframe and compares it bit by bit with the check bits as they arrive.
// Assumes a multiframe starts at the framing bit with index 0.
module t1fm_crc6
    import t1fm_pkg::*;
#(
    parameter int CRC_FIRST = 1,
    parameter int CRC_STEP  = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_valid,
    input  logic             fbit_strobe,
    input  logic             rx_bit,
    input  logic [IDX_W-1:0] frame_idx,
    input  logic             esf_mode,
    input  logic             in_sync,
    output logic             crc_err_evt
);
    localparam int CRC_LAST = CRC_FIRST + CRC_STEP * (CRC_W - 1);

    logic [CRC_W-1:0] crc_cur, crc_prev;
    logic             run_q, prev_ok, miss_q;
    logic             active, boundary, slot, last_slot, din, bit_miss;
    logic [2:0]       sel;

    // Decode multiframe start and check-bit positions
    always_comb begin
        active    = bit_valid && in_sync && esf_mode;
        boundary  = active && fbit_strobe && (frame_idx == '0);
        slot      = active && fbit_strobe && (frame_idx[1:0] == 2'(CRC_FIRST));
        last_slot = slot && (frame_idx == IDX_W'(CRC_LAST));
        din       = fbit_strobe ? 1'b1 : rx_bit;
        sel       = 3'(CRC_W - 1) - frame_idx[4:2];
        bit_miss  = rx_bit != crc_prev[sel];
        crc_err_evt = last_slot && prev_ok && (miss_q || bit_miss);
    end

    // Remainder accumulation, hand-over at the boundary, mismatch collection
    always_ff @(posedge clk) begin
        if (!rst_n || !in_sync || !esf_mode) begin
            crc_cur  <= '0;
            crc_prev <= '0;
            run_q    <= 1'b0;
            prev_ok  <= 1'b0;
            miss_q   <= 1'b0;
        end else if (bit_valid) begin
            if (boundary) begin
                crc_cur  <= crc_step('0, 1'b1);
                crc_prev <= crc_cur;
                prev_ok  <= run_q;
                run_q    <= 1'b1;
                miss_q   <= 1'b0;
            end else begin
                if (run_q) crc_cur <= crc_step(crc_cur, din);
                if (slot)  miss_q  <= miss_q || bit_miss;
            end
        end
    end

    AST_CRC_AT_LAST_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        crc_err_evt |-> (fbit_strobe && frame_idx == IDX_W'(CRC_LAST))); // R5
    AST_CRC_QUIET_OOS: assert property (@(posedge clk) disable iff (!rst_n)
        !in_sync |-> !crc_err_evt); // R8
endmodule

// File: rtl/t1fm_ind_reg.sv
// Sticky write-one-to-clear indication register with interrupt combine.
// Hardware sets take priority over software clears; the multiframe-start
// bit is frozen while out of sync.
module t1fm_ind_reg
    import t1fm_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [REG_W-1:0] set_vec,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    input  logic             in_sync,
    input  logic [REG_W-1:0] irq_en,
    output logic [REG_W-1:0] ind_q,
    output logic             irq
);
    logic [REG_W-1:0] clr_vec, ind_next;

    // Build the clear mask and the next register value
    always_comb begin
        clr_vec = wr_en ? wr_data : '0;
        if (!in_sync) clr_vec[B_MFB] = 1'b0;
        ind_next = ((ind_q & ~clr_vec) | set_vec) & LIVE_MASK;
    end

    // Register update
    always_ff @(posedge clk) begin
        if (!rst_n) ind_q <= '0;
        else        ind_q <= ind_next;
    end

    // Interrupt combine
    always_comb irq = |(ind_q & irq_en);

    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (ind_q & ~LIVE_MASK) == '0); // R10
    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        set_vec[B_FBIT] |=> ind_q[B_FBIT]); // R9
    AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_data[B_CRC] && !set_vec[B_CRC]) |=> !ind_q[B_CRC]); // R9
    AST_MFB_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        !in_sync |=> $stable(ind_q[B_MFB])); // R7
endmodule

// File: rtl/t1_fbit_monitor.sv
// Top of the T1 framing bit error monitor: framing-bit checker, ESF CRC-6
// checker and the sticky indication register. Assumes an aligned stream
// with frame indices supplied by the framer.
module t1_fbit_monitor
    import t1fm_pkg::*;
#(
    parameter int SEV_LIMIT = 2,
    parameter int SF_WIN    = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_bit,
    input  logic             bit_valid,
    input  logic             fbit_strobe,
    input  logic [IDX_W-1:0] frame_idx,
    input  logic             esf_mode,
    input  logic             in_sync,
    input  logic             cofa_in,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    input  logic [REG_W-1:0] irq_en,
    output logic [REG_W-1:0] ind_flags,
    output logic             irq
);
    logic             fe_evt, sev_evt, mfb_evt, crc_evt;
    logic [REG_W-1:0] set_vec;

    t1fm_fbit_check #(.SEV_LIMIT(SEV_LIMIT), .SF_WIN(SF_WIN)) u_fchk (
        .clk(clk), .rst_n(rst_n), .bit_valid(bit_valid), .fbit_strobe(fbit_strobe),
        .rx_bit(rx_bit), .frame_idx(frame_idx), .esf_mode(esf_mode), .in_sync(in_sync),
        .fe_evt(fe_evt), .sev_evt(sev_evt), .mfb_evt(mfb_evt)
    );

    t1fm_crc6 u_crc (
        .clk(clk), .rst_n(rst_n), .bit_valid(bit_valid), .fbit_strobe(fbit_strobe),
        .rx_bit(rx_bit), .frame_idx(frame_idx), .esf_mode(esf_mode), .in_sync(in_sync),
        .crc_err_evt(crc_evt)
    );

    // Gather event sources into register bit positions
    always_comb begin
        set_vec         = '0;
        set_vec[B_COFA] = cofa_in;
        set_vec[B_FBIT] = fe_evt;
        set_vec[B_CRC]  = crc_evt;
        set_vec[B_SEV]  = sev_evt;
        set_vec[B_MFB]  = mfb_evt;
    end

    t1fm_ind_reg u_reg (
        .clk(clk), .rst_n(rst_n), .set_vec(set_vec), .wr_en(wr_en), .wr_data(wr_data),
        .in_sync(in_sync), .irq_en(irq_en), .ind_q(ind_flags), .irq(irq)
    );

    AST_SEV_IMPLIES_FE: assert property (@(posedge clk) disable iff (!rst_n)
        sev_evt |=> (ind_flags[B_SEV] && ind_flags[B_FBIT])); // R2
endmodule

// File: tb/t1_fbit_monitor_test.sv
`timescale 1ns/1ps
module t1_fbit_monitor_test;
    localparam int FRAME_BITS = 193;
    localparam int NVEC = 14;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic       rst_n = 1'b0, rx_bit = 1'b0, bit_valid = 1'b0, fbit_strobe = 1'b0;
    logic [4:0] frame_idx = '0;
    logic       esf_mode = 1'b0, in_sync = 1'b1, cofa_in = 1'b0, wr_en = 1'b0;
    logic [7:0] wr_data = '0, irq_en = '0, ind_flags;
    logic       irq;

    int n_run = 0, n_fail = 0;
    logic [15:0] lfsr = 16'hACE1;
    logic [5:0]  crc_now = '0, crc_last = '0;

    t1_fbit_monitor uut (
        .clk(clk), .rst_n(rst_n), .rx_bit(rx_bit), .bit_valid(bit_valid),
        .fbit_strobe(fbit_strobe), .frame_idx(frame_idx), .esf_mode(esf_mode),
        .in_sync(in_sync), .cofa_in(cofa_in), .wr_en(wr_en), .wr_data(wr_data),
        .irq_en(irq_en), .ind_flags(ind_flags), .irq(irq)
    );

    // {esf, flip mask per frame index, expected register}
    localparam logic [32:0] VEC [NVEC] = '{
        {1'b0, 24'h000000, 8'h20}, {1'b0, 24'h000001, 8'h24},
        {1'b0, 24'h000002, 8'h24}, {1'b0, 24'h000005, 8'h34},
        {1'b0, 24'h000050, 8'h24}, {1'b0, 24'h00000A, 8'h24},
        {1'b0, 24'h000440, 8'h34}, {1'b1, 24'h000000, 8'h20},
        {1'b1, 24'h000008, 8'h24}, {1'b1, 24'h800008, 8'h34},
        {1'b1, 24'h000002, 8'h28}, {1'b1, 24'h000001, 8'h20},
        {1'b1, 24'h200020, 8'h28}, {1'b1, 24'h000880, 8'h34}
    };
    string vtag [NVEC] = '{"R7", "R1", "R1", "R2", "R2", "R2", "R2",
                           "R6", "R3", "R4", "R5", "R3", "R5", "R4"};

    function automatic logic [5:0] crc6(input logic [5:0] c, input logic d);
        logic top;
        top = c[5] ^ d;
        return top ? ({c[4:0], 1'b0} ^ 6'b000011) : {c[4:0], 1'b0};
    endfunction

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic drive(input logic b, input logic s, input int f);
        @(negedge clk);
        rx_bit = b; bit_valid = 1'b1; fbit_strobe = s; frame_idx = 5'(f);
    endtask

    task automatic wr(input logic [7:0] d);
        @(negedge clk); wr_en = 1'b1; wr_data = d;
        @(negedge clk); wr_en = 1'b0; wr_data = '0;
    endtask

    // Send one multiframe with the given framing bits inverted
    task automatic send_mf(input logic esf, input logic [23:0] mask);
        int nf;
        nf = esf ? 24 : 12;
        for (int f = 0; f < nf; f++) begin
            logic fb;
            if (!esf)          fb = (f % 2 == 0) ? 6'b010101 >> (f / 2) : 6'b011100 >> (f / 2);
            else if (f % 4 == 3) fb = 6'b110100 >> (f / 4);
            else if (f % 4 == 1) fb = crc_last[5 - f / 4];
            else                 fb = lfsr[0];
            fb = fb ^ mask[f];
            crc_now = crc6((f == 0) ? 6'd0 : crc_now, 1'b1);
            drive(fb, 1'b1, f);
            esf_mode = esf;
            for (int i = 1; i < FRAME_BITS; i++) begin
                lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
                crc_now = crc6(crc_now, lfsr[0]);
                drive(lfsr[0], 1'b0, 0);
            end
        end
        crc_last = crc_now;
        @(negedge clk); bit_valid = 1'b0; fbit_strobe = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog R-all actual=timeout expected=finish");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R10 reset", ind_flags, 8'h00);
        chk("R11 reset irq", {7'd0, irq}, 8'h00);

        // Vector table: one multiframe per entry, then clear everything
        for (int v = 0; v < NVEC; v++) begin
            send_mf(VEC[v][32], VEC[v][31:8]);
            chk(vtag[v], ind_flags, VEC[v][7:0]);
            wr(8'hFF);
        end

        // R11 interrupt enables
        send_mf(1'b0, 24'h000001);
        chk("R1 single Ft", ind_flags, 8'h24);
        @(negedge clk) irq_en = 8'h04;
        @(negedge clk) chk("R11 enabled", {7'd0, irq}, 8'h01);
        irq_en = 8'h10;
        @(negedge clk) chk("R11 masked", {7'd0, irq}, 8'h00);
        irq_en = 8'h00;

        // R9 selective clear
        wr(8'h04);
        chk("R9 selective", ind_flags, 8'h20);

        // R7 frozen, R8 silent while out of sync
        @(negedge clk) in_sync = 1'b0;
        wr(8'h20);
        chk("R7 frozen", ind_flags, 8'h20);
        send_mf(1'b0, 24'h000005);
        chk("R8 oos quiet", ind_flags, 8'h20);
        @(negedge clk) in_sync = 1'b1;
        wr(8'hFF);
        chk("R9 clear all", ind_flags, 8'h00);

        // R10 change-of-alignment bit and reserved bits
        @(negedge clk) cofa_in = 1'b1;
        @(negedge clk) cofa_in = 1'b0;
        chk("R10 cofa", ind_flags, 8'h02);
        wr(8'hFF);

        // R9 set wins over a same-cycle clear
        @(negedge clk) begin cofa_in = 1'b1; wr_en = 1'b1; wr_data = 8'h02; end
        @(negedge clk) begin cofa_in = 1'b0; wr_en = 1'b0; wr_data = '0; end
        chk("R9 set wins", ind_flags, 8'h02);
        wr(8'hFF);

        // R6 first multiframe after resync unchecked, R5 then checked
        @(negedge clk) in_sync = 1'b0;
        @(negedge clk) in_sync = 1'b1;
        send_mf(1'b1, 24'h000002);
        chk("R6 resync skip", ind_flags, 8'h20);
        wr(8'hFF);
        send_mf(1'b1, 24'h000002);
        chk("R5 crc after resync", ind_flags, 8'h28);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule